// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is a cycle-accurate model of a flow-through synchronous burst SRAM. Each word holds 18 bits, split into two 9-bit byte lanes. The depth is set by an address-width parameter. The nominal device uses 17 address bits; the default is smaller so that the model stays light. Every control and data input is captured on the rising clock edge. The address and the kind of access (read, write or none) are held in registers. Read data then flows straight from the storage array to the output in the cycle after that edge, with no further pipeline stage.

An access sequence starts on one of two strobes: a processor strobe or a controller strobe. The processor strobe has priority. After the start, a 2-bit counter steps through the two low address bits and wraps within a group of four words. A burst-advance input controls the counter; when that input is held inactive, the burst is suspended and the same word is accessed again. Writes can cover the whole word or be chosen per lane.

A sleep input deselects the device, and a fixed recovery period follows when it is released. Output enable only qualifies the data-valid flag.

Top module: `bsram_top`

## Requirements
- R1: All inputs are captured on the rising clock edge. For a read cycle, `rdata` shows the stored word at the registered address, and `rvalid` is high, from just after that edge until the next one.
- R2: A strobe (`strb_cpu_n` or `strb_ctl_n` low) loads `addr` only when `ce_hi`=1, `ce_lo_a_n`=0 and `ce_lo_b_n`=0. A strobe with any enable inactive ends the burst and makes no access. A cycle with no strobe and no open burst makes no access.
- R3: When `strb_cpu_n` is low, `strb_ctl_n` is ignored. The cycle is a read of `addr`, even if the write controls request a write.
- R4: In a burst cycle without a strobe, `adv_n`=0 sets the low two address bits to (start + count) mod 4 and keeps the upper bits. The fourth advance returns to the start word.
- R5: In a burst cycle without a strobe, `adv_n`=1 accesses the same word again, as a read or as a write.
- R6: `gw_n`=0 writes both lanes: lane 0 takes `wdata[8:0]` and lane 1 takes `wdata[17:9]`. The other write inputs make no difference.
- R7: With `gw_n`=1, `bwe_n`=1 makes the cycle a read. With `bwe_n`=0, each lane whose `bsel_n` bit is 0 is written, where bit 0 selects lane 0. If both bits are 1, the cycle is a read.
- R8: On the cycle a processor strobe starts a burst, no lane is written. Later burst cycles may write.
- R9: `rvalid` is low after a write cycle and after a cycle with no access. `oe_n`=1 forces `rvalid` low.
- R10: An edge with `sleep_req`=1 makes no access and ends the burst. After `sleep_req` returns to 0, the next two edges still make no access, and the third edge may start one. `rvalid` stays low throughout.
- R11: Synchronous reset `rst` clears the burst, the access kind and the recovery count. Stored data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address |
| ce_hi | input | 1 | Chip enable, active high |
| ce_lo_a_n | input | 1 | Chip enable, active low |
| ce_lo_b_n | input | 1 | Chip enable, active low |
| strb_cpu_n | input | 1 | Processor start strobe, active low, has priority |
| strb_ctl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends the burst |
| gw_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Lane-write enable, active low |
| bsel_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low; qualifies rvalid |
| sleep_req | input | 1 | Sleep request, active high |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rvalid | output | 1 | Read data valid |

## Verification
The two start strobes can arrive in the same cycle. When they do, one of them may also carry a write request. In that cycle the processor strobe must win, and its first-cycle write mask must also hold. The stimulus table holds rows with both strobes low while the whole-word write is active. The result is judged by reading the same word back afterwards and comparing it with an array model that was never written on that row. A second overlap is a sleep request during an open burst: the following burst cycles without a strobe must stay silent after wake-up.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int LANE_BITS   = 9;
    localparam int LANE_COUNT  = 2;
    localparam int BURST_BITS  = 2;
    localparam int WAKE_CYCLES = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        logic load;       // a strobe with the chip selected
        logic cpu_start;  // the load came from the processor strobe
        logic deselect;   // a strobe with the chip not selected
        logic resume;     // burst continuation, no strobe
    } start_t;

    function automatic start_t decode_start(input logic cpu_n, input logic ctl_n,
                                            input logic sel, input logic active,
                                            input logic allow);
        start_t s;
        s = '0;
        if (allow) begin
            if (!cpu_n || !ctl_n) begin
                if (sel) begin
                    s.load      = 1'b1;
                    s.cpu_start = !cpu_n;
                end else begin
                    s.deselect  = 1'b1;
                end
            end else if (active) begin
                s.resume = 1'b1;
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/bsram_sleep.sv
module bsram_sleep #(
    parameter int REC = bsram_pkg::WAKE_CYCLES,
    localparam int CW = $clog2(REC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_req,
    output logic allow
);
    logic [CW-1:0] rec_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else if (sleep_req) begin
            rec_q <= CW'(REC);
        end else if (rec_q != '0) begin
            rec_q <= rec_q - CW'(1);
        end
    end

    assign allow = !sleep_req && (rec_q == '0);

    // R10
    wake_block_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> !allow);
endmodule

// File: rtl/bsram_wdec.sv
module bsram_wdec #(
    parameter int LANES = bsram_pkg::LANE_COUNT
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    output logic [LANES-1:0] lanes,
    output logic             wr_req
);
    always_comb begin
        if (!gw_n) begin
            lanes = '1;
        end else if (!bwe_n) begin
            lanes = ~bsel_n;
        end else begin
            lanes = '0;
        end
    end

    assign wr_req = |lanes;
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              allow,
    input  logic              sel,
    input  logic              cpu_n,
    input  logic              ctl_n,
    input  logic              adv_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    output logic              acc_go,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] cur_addr_q,
    output acc_kind_e         cur_kind_q
);
    localparam int CW   = BURST_BITS;
    localparam int HI_W = ADDR_W - CW;

    logic [HI_W-1:0] hi_q, hi_d;
    logic [CW-1:0]   start_q, start_d, cnt_q, cnt_d;
    logic            act_q, act_d;
    start_t          st;

    always_comb begin
        st      = decode_start(cpu_n, ctl_n, sel, act_q, allow);
        hi_d    = hi_q;
        start_d = start_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        acc_go  = 1'b0;
        acc_wr  = 1'b0;
        if (!allow || st.deselect) begin
            act_d = 1'b0;
        end else if (st.load) begin
            hi_d    = addr[ADDR_W-1:CW];
            start_d = addr[CW-1:0];
            cnt_d   = '0;
            act_d   = 1'b1;
            acc_go  = 1'b1;
            acc_wr  = !st.cpu_start && wr_req;
        end else if (st.resume) begin
            if (!adv_n) begin
                cnt_d = cnt_q + CW'(1);
            end
            acc_go = 1'b1;
            acc_wr = wr_req;
        end
        acc_addr = {hi_d, start_d + cnt_d};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q       <= '0;
            start_q    <= '0;
            cnt_q      <= '0;
            act_q      <= 1'b0;
            cur_addr_q <= '0;
            cur_kind_q <= ACC_NONE;
        end else begin
            hi_q    <= hi_d;
            start_q <= start_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            if (acc_go) begin
                cur_addr_q <= acc_addr;
            end
            cur_kind_q <= acc_go ? (acc_wr ? ACC_WRITE : ACC_READ) : ACC_NONE;
        end
    end

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (allow && sel && (!cpu_n || !ctl_n)) |=> (cur_addr_q == $past(addr)));

    // R2
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (allow && !sel && (!cpu_n || !ctl_n)) |=> (cur_kind_q == ACC_NONE));

    // R3
    cpu_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (allow && sel && !cpu_n && !ctl_n) |=> (cur_kind_q == ACC_READ));

    // R4
    wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q && allow && cpu_n && ctl_n && !adv_n) |=>
        (cur_addr_q[CW-1:0] == CW'($past(cur_addr_q[CW-1:0]) + CW'(1))) &&
        (cur_addr_q[ADDR_W-1:CW] == $past(cur_addr_q[ADDR_W-1:CW])));

    // R5
    suspend_chk: assert property (@(posedge clk) disable iff (rst)
        (act_q && allow && cpu_n && ctl_n && adv_n) |=>
        ($stable(cur_addr_q) && cur_kind_q != ACC_NONE));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = bsram_pkg::LANE_BITS,
    parameter int LANES  = bsram_pkg::LANE_COUNT,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [ADDR_W-1:0]       raddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                lane_mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = lane_mem[raddr];
    end
endmodule

// File: rtl/bsram_top.sv
module bsram_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = LANE_BITS,
    parameter int LANES  = LANE_COUNT,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_hi,
    input  logic              ce_lo_a_n,
    input  logic              ce_lo_b_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bsel_n,
    input  logic              oe_n,
    input  logic              sleep_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    logic              allow, sel, wr_req, acc_go, acc_wr;
    logic [LANES-1:0]  lanes, we_lanes;
    logic [ADDR_W-1:0] acc_addr, cur_addr_q;
    acc_kind_e         cur_kind_q;

    assign sel = ce_hi && !ce_lo_a_n && !ce_lo_b_n;

    bsram_sleep #(.REC(WAKE_CYCLES)) u_sleep (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .allow(allow)
    );

    bsram_wdec #(.LANES(LANES)) u_wdec (
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
        .lanes(lanes), .wr_req(wr_req)
    );

    bsram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst(rst), .allow(allow), .sel(sel),
        .cpu_n(strb_cpu_n), .ctl_n(strb_ctl_n), .adv_n(adv_n),
        .wr_req(wr_req), .addr(addr),
        .acc_go(acc_go), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .cur_addr_q(cur_addr_q), .cur_kind_q(cur_kind_q)
    );

    assign we_lanes = lanes & {LANES{acc_wr}};

    bsram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .we(we_lanes), .waddr(acc_addr), .raddr(cur_addr_q),
        .wdata(wdata), .rdata(rdata)
    );

    assign rvalid = (cur_kind_q == ACC_READ) && !oe_n;

    // R8
    cpu_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (allow && sel && !strb_cpu_n) |-> (we_lanes == '0));

    // R9
    wr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_go && acc_wr) |=> !rvalid);

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> !rvalid);
endmodule

// File: tb/bsram_top_tb.sv
module bsram_top_tb;
    localparam int AW = 10;
    localparam int DW = 18;

    typedef struct packed {
        logic          cpu_n;
        logic          ctl_n;
        logic          adv_n;
        logic          gw_n;
        logic          bwe_n;
        logic [1:0]    bs_n;
        logic          en;
        logic          oe_n;
        logic          zz;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } vec_t;

    localparam int NV = 27;
    // fields: cpu_n ctl_n adv_n gw_n bwe_n bs_n en oe_n zz a d
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h010,18'h11111}, // 0  R6 ctl write
        '{1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h22222}, // 1  R4 write 011
        '{1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h23456}, // 2  R4 write 012
        '{1'b1,1'b1,1'b0,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h34567}, // 3  R4 write 013
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h012,18'h3ffff}, // 4  R8 masked
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 5  R4 013
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 6  R4 wrap 010
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 7  R5 suspend
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 8  R4 011
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 9  R4 012 start
        '{1'b0,1'b0,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h013,18'h00abc}, // 10 R3 both strobes
        '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b10,1'b1,1'b0,1'b0,10'h011,18'h3ffff}, // 11 R7 lane0
        '{1'b1,1'b1,1'b1,1'b1,1'b0,2'b01,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 12 R7 lane1
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h011,18'h00000}, // 13 R7 read back
        '{1'b1,1'b0,1'b1,1'b1,1'b0,2'b11,1'b1,1'b0,1'b0,10'h010,18'h2aaaa}, // 14 R7 no lane
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b1,1'b0,10'h011,18'h3ffff}, // 15 R9 oe high
        '{1'b1,1'b1,1'b1,1'b0,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h15555}, // 16 R8 later write
        '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 17 R5 reread
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b0,1'b0,1'b0,10'h013,18'h00000}, // 18 R2 deselect
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}, // 19 R2 idle
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h013,18'h00000}, // 20 R1 read
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,10'h012,18'h00000}, // 21 R10 sleep
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,10'h000,18'h00000}, // 22 R10 sleep
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h012,18'h00000}, // 23 R10 recover
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h012,18'h00000}, // 24 R10 recover
        '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h012,18'h00000}, // 25 R10 awake
        '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000}  // 26 R4 013
    };
    string TAGS [NV] = '{"R6","R4","R4","R4","R8","R4","R4","R5","R4","R4",
                         "R3","R7","R7","R7","R7","R9","R8","R5","R2","R2",
                         "R1","R10","R10","R10","R10","R10","R4"};

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] addr;
    logic          ce_hi, ce_lo_a_n, ce_lo_b_n;
    logic          strb_cpu_n, strb_ctl_n, adv_n, gw_n, bwe_n, oe_n, sleep_req;
    logic [1:0]    bsel_n;
    logic [DW-1:0] wdata, rdata;
    logic          rvalid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [DW-1:0] rmem   [1<<AW];
    logic [1:0]    rknown [1<<AW];
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    logic          m_act;
    int            m_rec;

    always #2.5ns clk = ~clk;

    bsram_top u_dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_hi(ce_hi),
        .ce_lo_a_n(ce_lo_a_n), .ce_lo_b_n(ce_lo_b_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
        .sleep_req(sleep_req), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        strb_cpu_n = v.cpu_n;
        strb_ctl_n = v.ctl_n;
        adv_n      = v.adv_n;
        gw_n       = v.gw_n;
        bwe_n      = v.bwe_n;
        bsel_n     = v.bs_n;
        ce_hi      = v.en;
        ce_lo_a_n  = !v.en;
        ce_lo_b_n  = !v.en;
        oe_n       = v.oe_n;
        sleep_req  = v.zz;
        addr       = v.a;
        wdata      = v.d;
    endtask

    function automatic vec_t idle_vec();
        return '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000};
    endfunction

    task automatic ref_step(input vec_t v, output logic ev,
                            output logic [DW-1:0] ed, output logic ek);
        logic          allow, go, wr;
        logic [1:0]    ln;
        logic [AW-1:0] ad;
        allow = !v.zz && (m_rec == 0);
        if (v.zz) m_rec = 2;
        else if (m_rec > 0) m_rec--;
        ln = !v.gw_n ? 2'b11 : (!v.bwe_n ? ~v.bs_n : 2'b00);
        go = 1'b0;
        wr = 1'b0;
        if (!allow) begin
            m_act = 1'b0;
        end else if (!v.cpu_n || !v.ctl_n) begin
            if (v.en) begin
                m_base = v.a;
                m_cnt  = 2'd0;
                m_act  = 1'b1;
                go     = 1'b1;
                wr     = v.cpu_n && (ln != 2'b00);
            end else begin
                m_act = 1'b0;
            end
        end else if (m_act) begin
            if (!v.adv_n) m_cnt = m_cnt + 2'd1;
            go = 1'b1;
            wr = (ln != 2'b00);
        end
        ad = {m_base[AW-1:2], m_base[1:0] + m_cnt};
        if (go && wr) begin
            if (ln[0]) rmem[ad][8:0]  = v.d[8:0];
            if (ln[1]) rmem[ad][17:9] = v.d[17:9];
            rknown[ad] = rknown[ad] | ln;
        end
        ev = go && !wr && !v.oe_n;
        ed = rmem[ad];
        ek = (rknown[ad] == 2'b11);
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic          ev, ek;
        logic [DW-1:0] ed;
        drive(v);
        ref_step(v, ev, ed, ek);
        @(posedge clk);
        @(negedge clk);
        chk(tag, "rvalid", 32'(rvalid), 32'(ev));
        if (ev && ek) chk(tag, "rdata", 32'(rdata), 32'(ed));
    endtask

    task automatic do_reset();
        drive(idle_vec());
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        m_act = 1'b0;
        m_rec = 0;
        m_cnt = 2'd0;
        rst   = 1'b0;
    endtask

    initial begin
        vec_t v;
        for (int i = 0; i < (1<<AW); i++) rknown[i] = 2'b00;
        m_base = '0;
        m_cnt  = 2'd0;
        m_act  = 1'b0;
        m_rec  = 0;
        drive(idle_vec());
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11", "rvalid in reset", 32'(rvalid), 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], TAGS[i]);
        end

        // R11: reset during an open burst, storage retained
        v = '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h010,18'h00000};
        run_vec(v, "R11");
        do_reset();
        chk("R11", "rvalid after reset", 32'(rvalid), 32'd0);
        v = '{1'b1,1'b1,1'b0,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h000,18'h00000};
        run_vec(v, "R11");
        v = '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h010,18'h00000};
        run_vec(v, "R11");
        chk("R11", "retained word", 32'(rdata), 32'h11111);

        // R11: reset clears the wake-up recovery count
        v = '{1'b1,1'b1,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b1,10'h000,18'h00000};
        run_vec(v, "R10");
        do_reset();
        v = '{1'b1,1'b0,1'b1,1'b1,1'b1,2'b11,1'b1,1'b0,1'b0,10'h013,18'h00000};
        run_vec(v, "R11");
        chk("R11", "read right after reset", 32'(rvalid), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule